// File: doc/BRIEF.md
# Program Counter with Latched Upper Bits

This block holds the 13-bit instruction address of a small microcontroller core. Every instruction cycle it either steps to the next address or takes one of three loads: a write to the low-byte register from the ALU, a jump or call target taken from an 11-bit opcode field, or a return address popped from the call stack. The five upper address bits can never be written directly. They come from a separate 5-bit holding latch that the core writes ahead of time.

The latch feeds the upper bits in two ways. A low-byte write takes all five latch bits as PC<12:8>. A jump or call takes only latch bits 4:3 as PC<12:11>, because the opcode field already supplies PC<10:0>. A return restores all 13 bits from the stack and leaves the latch alone. Each cycle a small priority arbiter chooses one source (`SRC_INC`, `SRC_LOWWR`, `SRC_JUMP`, `SRC_RET`), and a registered update moves the counter from that choice. The only state is the counter register and the latch register, so there are no sequencing states. Reset is synchronous and applies on the next clock edge.

Top module: `pc_unit`

## Requirements
- R1: With `rst` high at a rising edge, `pc`, `pcl_q` and `latch_q` are all zero after that edge.
- R2: With no load requested, `pc` advances by one on each edge and wraps from 0x1FFF to 0x0000.
- R3: A low-byte write (`pcl_wr`) sets `pc` to {`latch_q`[4:0], `alu_res`[7:0]}.
- R4: A jump or call (`jump_ld`) sets `pc` to {`latch_q`[4:3], `op_field`[10:0]}.
- R5: A return (`ret_ld`) sets `pc` to `stack_val`[12:0] and leaves `latch_q` unchanged.
- R6: A latch write (`latch_wr`) stores `latch_din`[4:0] into `latch_q`. Bits 7:5 of `latch_din` are discarded.
- R7: When several loads are requested in one cycle, return wins over jump, jump wins over low-byte write, and any load wins over increment.
- R8: A load uses the latch value held before the edge, even if the latch is written in the same cycle. Without `latch_wr`, `latch_q` holds its value whatever the counter does.
- R9: `pcl_q` always equals `pc`[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction cycle per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pcl_wr | input | 1 | Write the low-byte register from the ALU |
| alu_res | input | 8 | ALU result for a low-byte write |
| jump_ld | input | 1 | Jump or call load |
| op_field | input | 11 | Target field from the opcode |
| ret_ld | input | 1 | Return load from the stack |
| stack_val | input | 13 | Popped return address |
| latch_wr | input | 1 | Write the holding latch |
| latch_din | input | 8 | Latch write data; low 5 bits are kept |
| pc | output | 13 | Current program counter |
| pcl_q | output | 8 | Readable low-byte register |
| latch_q | output | 5 | Holding latch contents |

## Verification
Every result of this block, whether a step, one of the three loads, a latch write or a reset, appears exactly one rising edge after the cycle that requested it. The bench drives each stimulus on a falling edge. It advances a behavioural model of the counter and the latch across the following rising edge, using the inputs and the model state from before that edge. It then compares all three outputs on the next falling edge, so each check samples right after the single register stage and before the next stimulus is applied.

// File: rtl/pc_pkg.sv
package pc_pkg;
    typedef enum logic [1:0] {
        SRC_INC   = 2'd0,
        SRC_LOWWR = 2'd1,
        SRC_JUMP  = 2'd2,
        SRC_RET   = 2'd3
    } pc_src_e;
endpackage

// File: rtl/pc_src_arb.sv
module pc_src_arb
    import pc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ret_ld,
    input  logic    jump_ld,
    input  logic    pcl_wr,
    output pc_src_e src
);
    always_comb begin
        if (ret_ld)       src = SRC_RET;
        else if (jump_ld) src = SRC_JUMP;
        else if (pcl_wr)  src = SRC_LOWWR;
        else              src = SRC_INC;
    end

    // R7: a return outranks every other request
    a_r7_ret_wins: assert property (@(posedge clk) disable iff (rst)
        ret_ld |-> src == SRC_RET);
    // R7: a jump outranks a low-byte write
    a_r7_jump_over_wr: assert property (@(posedge clk) disable iff (rst)
        (jump_ld && !ret_ld) |-> src == SRC_JUMP);
endmodule

// File: rtl/pc_hold_latch.sv
module pc_hold_latch #(
    parameter int DATA_W  = 8,
    parameter int LATCH_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [DATA_W-1:0]  din,
    output logic [LATCH_W-1:0] q
);
    logic unused_hi;
    assign unused_hi = ^din[DATA_W-1:LATCH_W];

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= din[LATCH_W-1:0];
    end

    // R8: the latch moves only on its own write strobe
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(q));
    // R6: a write keeps the low bits of the data
    a_r6_latch_store: assert property (@(posedge clk) disable iff (rst)
        wr |=> q == $past(din[LATCH_W-1:0]));
endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
    import pc_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LO_W    = 8,
    parameter int OP_W    = 11,
    parameter int LATCH_W = 5
) (
    input  pc_src_e            src,
    input  logic [PC_W-1:0]    pc_cur,
    input  logic [LO_W-1:0]    alu_res,
    input  logic [OP_W-1:0]    op_field,
    input  logic [PC_W-1:0]    stack_val,
    input  logic [LATCH_W-1:0] latch_q,
    output logic [PC_W-1:0]    pc_nxt
);
    localparam int HI_W  = PC_W - LO_W;
    localparam int JHI_W = PC_W - OP_W;

    always_comb begin
        unique case (src)
            SRC_INC:   pc_nxt = pc_cur + PC_W'(1);
            SRC_LOWWR: pc_nxt = {latch_q[HI_W-1:0], alu_res};
            SRC_JUMP:  pc_nxt = {latch_q[LATCH_W-1 -: JHI_W], op_field};
            SRC_RET:   pc_nxt = stack_val;
            default:   pc_nxt = pc_cur;
        endcase
    end
endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import pc_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LO_W    = 8,
    parameter int OP_W    = 11,
    parameter int LATCH_W = 5,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pcl_wr,
    input  logic [LO_W-1:0]    alu_res,
    input  logic               jump_ld,
    input  logic [OP_W-1:0]    op_field,
    input  logic               ret_ld,
    input  logic [PC_W-1:0]    stack_val,
    input  logic               latch_wr,
    input  logic [DATA_W-1:0]  latch_din,
    output logic [PC_W-1:0]    pc,
    output logic [LO_W-1:0]    pcl_q,
    output logic [LATCH_W-1:0] latch_q
);
    localparam int HI_W  = PC_W - LO_W;
    localparam int JHI_W = PC_W - OP_W;

    pc_src_e         src;
    logic [PC_W-1:0] pc_nxt;

    pc_src_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .ret_ld  (ret_ld),
        .jump_ld (jump_ld),
        .pcl_wr  (pcl_wr),
        .src     (src)
    );

    pc_hold_latch #(.DATA_W(DATA_W), .LATCH_W(LATCH_W)) u_latch (
        .clk (clk),
        .rst (rst),
        .wr  (latch_wr),
        .din (latch_din),
        .q   (latch_q)
    );

    pc_next_mux #(.PC_W(PC_W), .LO_W(LO_W), .OP_W(OP_W), .LATCH_W(LATCH_W)) u_mux (
        .src       (src),
        .pc_cur    (pc),
        .alu_res   (alu_res),
        .op_field  (op_field),
        .stack_val (stack_val),
        .latch_q   (latch_q),
        .pc_nxt    (pc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_nxt;
    end

    assign pcl_q = pc[LO_W-1:0];

    // R1: reset clears the counter
    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> pc == '0);
    // R2: step by one when idle
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (!ret_ld && !jump_ld && !pcl_wr) |=> pc == $past(pc) + PC_W'(1));
    // R3: low-byte write combines all latch bits with the ALU byte
    a_r3_low_write: assert property (@(posedge clk) disable iff (rst)
        (pcl_wr && !jump_ld && !ret_ld) |=>
            pc == {$past(latch_q[HI_W-1:0]), $past(alu_res)});
    // R4: jump takes the top latch bits and the opcode field
    a_r4_jump: assert property (@(posedge clk) disable iff (rst)
        (jump_ld && !ret_ld) |=>
            pc == {$past(latch_q[LATCH_W-1 -: JHI_W]), $past(op_field)});
    // R5: return restores the stacked address
    a_r5_return: assert property (@(posedge clk) disable iff (rst)
        ret_ld |=> pc == $past(stack_val));
endmodule

// File: tb/pc_unit_tb.sv
module pc_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        pcl_wr, jump_ld, ret_ld, latch_wr;
    logic [7:0]  alu_res, latch_din;
    logic [10:0] op_field;
    logic [12:0] stack_val;
    logic [12:0] pc;
    logic [7:0]  pcl_q;
    logic [4:0]  latch_q;

    int vectors = 0;
    int fails   = 0;
    int m_pc    = 0;
    int m_lat   = 0;

    always #10 clk = ~clk;

    pc_unit u_dut (
        .clk(clk), .rst(rst), .pcl_wr(pcl_wr), .alu_res(alu_res),
        .jump_ld(jump_ld), .op_field(op_field), .ret_ld(ret_ld),
        .stack_val(stack_val), .latch_wr(latch_wr), .latch_din(latch_din),
        .pc(pc), .pcl_q(pcl_q), .latch_q(latch_q)
    );

    task automatic check(input string tag);
        vectors++;
        if (int'(pc) != m_pc || int'(pcl_q) != (m_pc & 'hFF) || int'(latch_q) != m_lat) begin
            fails++;
            $display("FAIL %s: pc=%h pcl=%h latch=%h expected pc=%h pcl=%h latch=%h",
                     tag, pc, pcl_q, latch_q, m_pc[12:0], m_pc[7:0], m_lat[4:0]);
        end
    endtask

    // one instruction cycle: drive at negedge, model the edge, compare at next negedge
    task automatic step(input logic r, input logic pw, input logic [7:0] alu,
                        input logic jl, input logic [10:0] op,
                        input logic rl, input logic [12:0] sv,
                        input logic lw, input logic [7:0] ld, input string tag);
        int n_pc, n_lat;
        rst = r; pcl_wr = pw; alu_res = alu; jump_ld = jl; op_field = op;
        ret_ld = rl; stack_val = sv; latch_wr = lw; latch_din = ld;
        n_lat = m_lat;
        if (r) begin
            n_pc = 0; n_lat = 0;
        end else begin
            if (rl)      n_pc = int'(sv);
            else if (jl) n_pc = ((m_lat >> 3) * 2048) + int'(op);
            else if (pw) n_pc = (m_lat * 256) + int'(alu);
            else         n_pc = (m_pc + 1) % 8192;
            if (lw) n_lat = int'(ld) % 32;
        end
        @(posedge clk);
        m_pc = n_pc; m_lat = n_lat;
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 8'h00, 0, 11'h000, 0, 13'h0000, 0, 8'h00, tag);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1; pcl_wr = 0; jump_ld = 0; ret_ld = 0; latch_wr = 0;
        alu_res = 0; op_field = 0; stack_val = 0; latch_din = 0;
        @(negedge clk);
        // R1 reset state
        step(1, 0, 8'h00, 0, 11'h000, 0, 13'h0000, 0, 8'h00, "R1");
        step(1, 1, 8'hAA, 1, 11'h7FF, 0, 13'h0000, 1, 8'hFF, "R1");
        // R2 plain stepping
        for (int i = 0; i < 5; i++) idle("R2");
        // R5 return to near the top, then R2 wrap
        step(0, 0, 8'h00, 0, 11'h000, 1, 13'h1FFE, 0, 8'h00, "R5");
        idle("R2"); idle("R2"); idle("R2");
        // R6 latch write discards upper data bits
        step(0, 0, 8'h00, 0, 11'h000, 0, 13'h0000, 1, 8'hFF, "R6");
        // R3 low-byte write with full latch
        step(0, 1, 8'h34, 0, 11'h000, 0, 13'h0000, 0, 8'h00, "R3");
        idle("R9");
        // R4 jump uses latch bits 4:3
        step(0, 0, 8'h00, 1, 11'h5A5, 0, 13'h0000, 0, 8'h00, "R4");
        step(0, 0, 8'h00, 0, 11'h000, 0, 13'h0000, 1, 8'hEA, "R6");
        step(0, 0, 8'h00, 1, 11'h123, 0, 13'h0000, 0, 8'h00, "R4");
        step(0, 1, 8'hC0, 0, 11'h000, 0, 13'h0000, 0, 8'h00, "R3");
        // R5 return leaves the latch alone
        step(0, 0, 8'h00, 0, 11'h000, 1, 13'h0ABC, 0, 8'h00, "R5");
        // R7 priority mixes
        step(0, 1, 8'h11, 1, 11'h222, 1, 13'h1333, 0, 8'h00, "R7");
        step(0, 1, 8'h11, 1, 11'h222, 0, 13'h0000, 0, 8'h00, "R7");
        step(0, 1, 8'h77, 0, 11'h000, 0, 13'h0000, 0, 8'h00, "R7");
        // R8 latch write in the same cycle as a load uses the old latch
        step(0, 0, 8'h00, 1, 11'h0F0, 0, 13'h0000, 1, 8'h18, "R8");
        step(0, 1, 8'h55, 0, 11'h000, 0, 13'h0000, 1, 8'h03, "R8");
        step(0, 0, 8'h00, 1, 11'h001, 0, 13'h0000, 0, 8'h00, "R8");
        // R1 reset mid-run
        step(1, 0, 8'h00, 0, 11'h000, 0, 13'h0000, 0, 8'h00, "R1");
        idle("R2");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 50) == 0, ($urandom % 4) == 0, 8'($urandom),
                 ($urandom % 5) == 0, 11'($urandom), ($urandom % 7) == 0,
                 13'($urandom), ($urandom % 3) == 0, 8'($urandom), "R7 mixed");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule